// File: doc/BRIEF.md
# Two-Level Return Address Stack

This block holds subroutine return addresses in two fixed storage levels, with no pointer. A call event pushes the address supplied by the program counter logic. A return event pops the stack, and the program counter logic takes the top entry as its next address. The stack has no push or pop opcodes of its own. It is driven only by these two strobes.

Overflow and underflow pass without any indication. A third push in a row drops the oldest address. When pops outrun pushes, each extra pop returns a copy of whatever the deeper level held last. The stored addresses are not touched by reset. The reset input only freezes the stack: it holds the stack while reset is asserted and until its synchronised release has reached the block.

Top module: `ret_stack2`

## Requirements
- R1: The output `tos_o` always shows the content of level 1, the top entry. Level 2 sits directly beneath it, and the stack has no other storage.
- R2: On a clock edge with an accepted push, level 1 takes the value of `push_addr_i` and level 2 takes the previous value of level 1.
- R3: After three or more pushes in a row, only the two most recent addresses remain. Popping then returns the newest address first and the second newest address after it.
- R4: On a clock edge with an accepted pop, the value on `tos_o` before the edge is the return address. Level 1 then takes the value of level 2, and level 2 keeps its own value.
- R5: When more pops follow than pushes preceded them, every further pop returns the value that was last held in level 2.
- R6: When `push_i` and `pop_i` are both high on the same edge, the stack performs only the push.
- R7: On an edge where neither strobe is accepted, both levels hold their values.
- R8: Reset leaves both stored levels unchanged. Strobes are ignored while `rst_n` is low and for the first two rising clock edges after `rst_n` goes high.
- R9: The block has no overflow or underflow output. Overflow and underflow change nothing except the levels, as described in R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| push_i | input | 1 | Call event strobe |
| push_addr_i | input | 12 | Return address to store on a push |
| pop_i | input | 1 | Return event strobe |
| tos_o | output | 12 | Top-of-stack return address (level 1) |

## Verification
Several properties are checked on every cycle:
- the level shift for push and pop, including the bottom level holding its value on a pop;
- that idle cycles hold both levels;
- that push wins when both strobes arrive together;
- that no operation is decoded while the synchronised reset is active.

Other behaviours only show up in the bench's scenarios, which compare against a queue model on every clock. These are:
- the loss of the oldest address over a run of pushes;
- the repeated level-2 value across a run of pops;
- the survival of the contents through a reset pulse;
- the exact two-edge window after release in which strobes are ignored.

// File: rtl/ret_stack2_pkg.sv
package ret_stack2_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } rs_op_e;
endpackage

// File: rtl/rs_rst_sync.sv
module rs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rs_op_decode.sv
module rs_op_decode
  import ret_stack2_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   push,
  input  logic   pop,
  output rs_op_e op
);
  always_comb begin
    op = OP_HOLD;
    if (enable) begin
      if (push)     op = OP_PUSH;
      else if (pop) op = OP_POP;
    end
  end

  // R6: push wins over a simultaneous pop
  a_r6_push_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && push && pop) |-> (op == OP_PUSH));

  // R8: nothing is decoded while the synchronised reset is active
  always_comb begin
    if (enable === 1'b0) begin
      a_r8_gated: assert (op == OP_HOLD);
    end
  end
endmodule

// File: rtl/rs_level.sv
module rs_level
  import ret_stack2_pkg::*;
#(
  parameter int  AW        = 12,
  parameter bit  IS_BOTTOM = 1'b0
) (
  input  logic          clk,
  input  rs_op_e        op,
  input  logic [AW-1:0] from_above,
  input  logic [AW-1:0] from_below,
  output logic [AW-1:0] q
);
  logic          en;
  logic [AW-1:0] d;

  always_comb begin
    en = 1'b0;
    d  = q;
    case (op)
      OP_PUSH: begin
        en = 1'b1;
        d  = from_above;
      end
      OP_POP: begin
        en = !IS_BOTTOM;
        d  = from_below;
      end
      default: begin
        en = 1'b0;
        d  = q;
      end
    endcase
  end

  // Stored content is deliberately not reset (R8)
  always_ff @(posedge clk) begin
    if (en) q <= d;
  end
endmodule

// File: rtl/ret_stack2.sv
module ret_stack2
  import ret_stack2_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic [AW-1:0] tos_o
);
  localparam int LAST = DEPTH - 1;

  logic          rst_sync_n;
  rs_op_e        op;
  logic [AW-1:0] lvl [DEPTH];

  rs_rst_sync #(.STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rs_op_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (rst_sync_n),
    .push   (push_i),
    .pop    (pop_i),
    .op     (op)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [AW-1:0] above;
    logic [AW-1:0] below;
    if (i == 0) begin : g_top
      assign above = push_addr_i;
    end else begin : g_mid
      assign above = lvl[i-1];
    end
    if (i == LAST) begin : g_bot
      assign below = lvl[i];
    end else begin : g_up
      assign below = lvl[i+1];
    end
    rs_level #(.AW(AW), .IS_BOTTOM(i == LAST)) u_lvl (
      .clk        (clk),
      .op         (op),
      .from_above (above),
      .from_below (below),
      .q          (lvl[i])
    );
  end

  assign tos_o = lvl[0];

  // R2: push writes level 1 and shifts level 1 into level 2
  a_r2_push_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH) |=> ((lvl[0] === $past(push_addr_i)) && (lvl[1] === $past(lvl[0]))));

  // R4: pop moves level 2 up and keeps level 2
  a_r4_pop_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP) |=> ((lvl[0] === $past(lvl[1])) && (lvl[LAST] === $past(lvl[LAST]))));

  // R7: idle edges hold both levels
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> ((lvl[0] === $past(lvl[0])) && (lvl[1] === $past(lvl[1]))));

  // R1: the output is the top level
  a_r1_tos_level1: assert property (@(posedge clk) disable iff (!rst_n)
    tos_o === lvl[0]);
endmodule

// File: tb/tb_ret_stack2.sv
module tb_ret_stack2;
  localparam int AW = 12;

  logic          clk;
  logic          rst_n;
  logic          push_i;
  logic [AW-1:0] push_addr_i;
  logic          pop_i;
  logic [AW-1:0] tos_o;

  int checks;
  int errors;
  string tag;

  logic [AW-1:0] mq[$];
  int            rel_cnt;

  ret_stack2 #(.AW(AW), .DEPTH(2)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_addr_i (push_addr_i),
    .pop_i       (pop_i),
    .tos_o       (tos_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s tos actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      rel_cnt = 0;
    end else begin
      if (rel_cnt >= 2) begin
        if (push_i) begin
          mq.push_front(push_addr_i);
          if (mq.size() > 2) void'(mq.pop_back());
        end else if (pop_i) begin
          if (mq.size() == 2) mq[0] = mq[1];
          else if (mq.size() == 1) mq.delete();
        end
      end
      if (rel_cnt < 2) rel_cnt++;
    end
  end

  always @(negedge clk) begin
    if (mq.size() > 0) check(tag, tos_o, mq[0]);
  end

  task automatic op(input logic pu, input logic po, input logic [AW-1:0] a);
    push_i = pu; pop_i = po; push_addr_i = a;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [AW-1:0] exp);
    check(req, tos_o, exp);
    op(1'b0, 1'b1, '0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; rel_cnt = 0; tag = "R1";
    rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0; push_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 push shifting, R1 top visible
    tag = "R2";
    op(1'b1, 1'b0, 12'h0A1);
    check("R1", tos_o, 12'h0A1);
    op(1'b1, 1'b0, 12'h0B2);
    check("R2", tos_o, 12'h0B2);
    pop_expect("R2", 12'h0B2);
    check("R2", tos_o, 12'h0A1);

    // R3 overflow: push three, oldest lost
    tag = "R3";
    op(1'b1, 1'b0, 12'h111);
    op(1'b1, 1'b0, 12'h222);
    op(1'b1, 1'b0, 12'h333);
    check("R3", tos_o, 12'h333);
    pop_expect("R3", 12'h333);
    pop_expect("R3", 12'h222);

    // R5 underflow: further pops repeat level-2 value, R9 silent
    tag = "R5";
    pop_expect("R5", 12'h222);
    pop_expect("R5", 12'h222);
    pop_expect("R9", 12'h222);

    // R4 pop leaves level 2 intact
    tag = "R4";
    op(1'b1, 1'b0, 12'h3C0);
    op(1'b1, 1'b0, 12'h3C1);
    pop_expect("R4", 12'h3C1);
    check("R4", tos_o, 12'h3C0);
    pop_expect("R4", 12'h3C0);
    check("R4", tos_o, 12'h3C0);

    // R6 simultaneous push and pop
    tag = "R6";
    op(1'b1, 1'b1, 12'h5A5);
    check("R6", tos_o, 12'h5A5);
    pop_expect("R6", 12'h5A5);
    check("R6", tos_o, 12'h3C0);

    // R7 idle cycles with changing data
    tag = "R7";
    op(1'b1, 1'b0, 12'h777);
    push_addr_i = 12'hFFF;
    repeat (4) @(negedge clk);
    check("R7", tos_o, 12'h777);

    // R8 reset retains contents and gates strobes
    tag = "R8";
    op(1'b1, 1'b0, 12'h888);
    rst_n = 1'b0;
    push_i = 1'b1; push_addr_i = 12'h999;
    repeat (3) @(negedge clk);
    check("R8", tos_o, 12'h888);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8", tos_o, 12'h888);
    push_i = 1'b0;
    pop_expect("R8", 12'h888);
    pop_expect("R8", 12'h777);

    // R8 first accepted edge after release is the third
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    pop_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8", tos_o, 12'h777);
    op(1'b1, 1'b0, 12'hABC);
    check("R8", tos_o, 12'hABC);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule